// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block is a calendar clock that counts in 24-hour packed BCD. A free-running 32768 Hz tick enable feeds a prescaler. On every full second the prescaler advances the time fields: seconds, minutes, hours, day of month, month and a two-digit year. A two-digit year `nn` stands for 20nn. Software reaches the time registers, a matching set of alarm registers, and the control, status and interrupt-enable registers over a byte-wide register bus. Reads on that bus return their data one cycle later.

The alarm compares all six alarm bytes with the running time after every second step. There is no wildcard field. A match sets a sticky status flag. Two interrupt lines leave the block. One follows the enabled alarm flag. The other gives one pulse per second when enabled. A busy bit tells software that a second step is about to happen, so it can wait for the safe access window that follows.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the time reads 00:00:00 on day 01, month 01, year 00. Control and interrupt-enable read 0x00, status reads 0x80, and both interrupt outputs are low.
- R2: The clock counts only while control bit 0 is 1, and only on cycles where `tick_en` is high. After `TICKS_PER_SEC` counted ticks the seconds field advances by one.
- R3: Seconds and minutes wrap from 59 to 00 and hours from 23 to 00. Each wrap carries into the next field.
- R4: The day wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, 31 for the other months, and 28 for month 02. Month 02 has 29 days when the BCD year is a multiple of 4, including 00. The month wraps from 12 to 01 and the year from 99 to 00.
- R5: A write to a time register loads that byte at once. A write to seconds restarts the prescaler, so the next step comes a full `TICKS_PER_SEC` ticks later. A second step that falls in the same cycle as any time-register write is dropped.
- R6: Status bit 6 (alarm) is set after a step that leaves all six time bytes (0x00..0x14) equal to the six alarm bytes (0x20..0x34, same field order). If any single byte differs, the bit is not set.
- R7: At status address 0x44, writing 1 to bit 7 (power-up) or bit 6 (alarm) clears that bit. Writing 0 leaves them unchanged, and writes to bits 5..0 have no effect.
- R8: Status bit 0 (busy) is 1 while running and the prescaler is in its last tick period before a step. Status bit 1 mirrors control bit 0.
- R9: Status bits 2, 3, 4 and 5 are reloaded at every step. Bit 2 becomes 1. Bit 3 marks a minute rollover, bit 4 an hour rollover and bit 5 a day rollover. The values hold until the next step.
- R10: `irq_alarm` equals the registered value of status bit 6 AND interrupt-enable bit 3 (address 0x48), one cycle late. When interrupt-enable bit 2 is set, `irq_sec` pulses high for one cycle, one cycle after each step.
- R11: Read data appears on `bus_rdata` one cycle after a read and holds until the next read. Control (0x40) keeps only bits 7, 3, 2 and 0. Interrupt-enable keeps only bits 3 and 2. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | 32768 Hz tick enable, one cycle wide |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_alarm | output | 1 | Alarm interrupt level |
| irq_sec | output | 1 | Once-per-second interrupt pulse |

## Verification
Each result has a fixed due cycle:

| Result | Due |
|---|---|
| Register read | Edge after the access |
| Second step | `TICKS_PER_SEC`-th counted tick after a seconds write or run start |
| Alarm flag | Edge after the step |
| `irq_sec` | Edge after the step |
| `irq_alarm` | Edge after the flag |

The bench model moves its state at the same edges, and every output is compared half a cycle later on each clock. Directed checks wait 18 to 20 cycles after starting a 16-tick second before they read. This keeps exactly one step inside the window, so the literal expected values are exact.

// File: rtl/bcd_rtc_pkg.sv
`timescale 1ns/1ps
package bcd_rtc_pkg;
  localparam int NFIELD = 6;
  typedef logic [NFIELD-1:0][7:0] cal_t;   // [0]=sec ... [5]=year

  localparam logic [7:0] ADR_CTRL = 8'h40;
  localparam logic [7:0] ADR_STAT = 8'h44;
  localparam logic [7:0] ADR_IEN  = 8'h48;
  localparam logic [7:0] CTRL_KEEP = 8'h8D;
  localparam logic [7:0] IEN_KEEP  = 8'h0C;

  // Floor value of each field: also its reset value
  localparam cal_t FIELD_FLOOR = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] month_end(input logic [7:0] mon, input logic [7:0] yr);
    logic [1:0] m4;
    m4 = {yr[4], 1'b0} + yr[1:0];   // tens*10 mod 4 plus units mod 4
    case (mon)
      8'h02:                      return (m4 == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/bcd_rtc_prescaler.sv
`timescale 1ns/1ps
module bcd_rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic tick_i,
  input  logic restart_i,
  output logic strobe_o,
  output logic busy_o
);
  localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i)       cnt_q <= '0;
    else if (run_i && tick_i)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign busy_o   = run_i && (cnt_q == LAST);
  assign strobe_o = busy_o && tick_i && !restart_i;

  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  a_r5_restart_zero: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (cnt_q == '0));
endmodule

// File: rtl/bcd_rtc_calendar.sv
`timescale 1ns/1ps
module bcd_rtc_calendar
  import bcd_rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_field_i,
  input  logic [7:0] wr_data_i,
  output cal_t       time_o,
  output logic       stepped_o,
  output logic [3:0] evt_o      // {day, hour, minute, second}
);
  cal_t              fld_q;
  cal_t              top_v;
  logic [NFIELD:0]   carry;
  logic              do_step;

  assign do_step  = step_i && !wr_en_i;
  assign carry[0] = do_step;

  always_comb begin
    top_v[0] = 8'h59;
    top_v[1] = 8'h59;
    top_v[2] = 8'h23;
    top_v[3] = month_end(fld_q[4], fld_q[5]);
    top_v[4] = 8'h12;
    top_v[5] = 8'h99;
  end

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    assign carry[i+1] = carry[i] && (fld_q[i] == top_v[i]);
    always_ff @(posedge clk) begin
      if (rst)
        fld_q[i] <= FIELD_FLOOR[i];
      else if (wr_en_i && (wr_field_i == 3'(i)))
        fld_q[i] <= wr_data_i;
      else if (carry[i])
        fld_q[i] <= (fld_q[i] == top_v[i]) ? FIELD_FLOOR[i] : bcd_inc(fld_q[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stepped_o <= 1'b0;
      evt_o     <= '0;
    end else begin
      stepped_o <= do_step;
      if (do_step) evt_o <= carry[3:0];
    end
  end

  assign time_o = fld_q;

  a_r3_step_moves_sec: assert property (@(posedge clk) disable iff (rst)
    do_step |=> (fld_q[0] != $past(fld_q[0])));
  a_r9_day_implies_hour: assert property (@(posedge clk) disable iff (rst)
    evt_o[3] |-> (evt_o[2] && evt_o[1] && evt_o[0]));
endmodule

// File: rtl/bcd_rtc_alarm.sv
`timescale 1ns/1ps
module bcd_rtc_alarm
  import bcd_rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en_i,
  input  logic [2:0] wr_field_i,
  input  logic [7:0] wr_data_i,
  input  cal_t       time_i,
  input  logic       stepped_i,
  output cal_t       alarm_o,
  output logic       hit_o
);
  cal_t al_q;

  for (genvar i = 0; i < NFIELD; i++) begin : g_alm
    always_ff @(posedge clk) begin
      if (rst)                                     al_q[i] <= 8'h00;
      else if (wr_en_i && (wr_field_i == 3'(i)))   al_q[i] <= wr_data_i;
    end
  end

  assign alarm_o = al_q;
  assign hit_o   = stepped_i && (time_i == al_q);
endmodule

// File: rtl/bcd_rtc.sv
`timescale 1ns/1ps
module bcd_rtc
  import bcd_rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic       bus_en,
  input  logic       bus_we,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq_alarm,
  output logic       irq_sec
);
  logic       in_fields, time_sel, alm_sel, wr, rd;
  logic       time_wr, alm_wr, stat_wr;
  logic [2:0] fidx;
  logic [7:0] ctrl_q, ien_q, rd_mux;
  logic       pu_q, al_q;
  logic       strobe, busy, stepped, hit;
  logic [3:0] evt;
  cal_t       cur_time, alm_time;

  assign wr        = bus_en && bus_we;
  assign rd        = bus_en && !bus_we;
  assign fidx      = bus_addr[4:2];
  assign in_fields = (bus_addr[1:0] == 2'b00) && (fidx <= 3'd5);
  assign time_sel  = in_fields && (bus_addr[7:5] == 3'b000);
  assign alm_sel   = in_fields && (bus_addr[7:5] == 3'b001);
  assign time_wr   = wr && time_sel;
  assign alm_wr    = wr && alm_sel;
  assign stat_wr   = wr && (bus_addr == ADR_STAT);

  bcd_rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
    .clk(clk), .rst(rst), .run_i(ctrl_q[0]), .tick_i(tick_en),
    .restart_i(time_wr && (fidx == 3'd0)),
    .strobe_o(strobe), .busy_o(busy)
  );

  bcd_rtc_calendar u_cal (
    .clk(clk), .rst(rst), .step_i(strobe),
    .wr_en_i(time_wr), .wr_field_i(fidx), .wr_data_i(bus_wdata),
    .time_o(cur_time), .stepped_o(stepped), .evt_o(evt)
  );

  bcd_rtc_alarm u_alm (
    .clk(clk), .rst(rst),
    .wr_en_i(alm_wr), .wr_field_i(fidx), .wr_data_i(bus_wdata),
    .time_i(cur_time), .stepped_i(stepped),
    .alarm_o(alm_time), .hit_o(hit)
  );

  always_comb begin
    rd_mux = 8'h00;
    if (time_sel)                   rd_mux = cur_time[fidx];
    else if (alm_sel)               rd_mux = alm_time[fidx];
    else if (bus_addr == ADR_CTRL)  rd_mux = ctrl_q;
    else if (bus_addr == ADR_STAT)  rd_mux = {pu_q, al_q, evt, ctrl_q[0], busy};
    else if (bus_addr == ADR_IEN)   rd_mux = ien_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= 8'h00;
      ien_q     <= 8'h00;
      pu_q      <= 1'b1;
      al_q      <= 1'b0;
      bus_rdata <= 8'h00;
      irq_alarm <= 1'b0;
      irq_sec   <= 1'b0;
    end else begin
      if (wr && (bus_addr == ADR_CTRL)) ctrl_q <= bus_wdata & CTRL_KEEP;
      if (wr && (bus_addr == ADR_IEN))  ien_q  <= bus_wdata & IEN_KEEP;
      if (stat_wr && bus_wdata[7])      pu_q   <= 1'b0;
      if (hit)                          al_q   <= 1'b1;
      else if (stat_wr && bus_wdata[6]) al_q   <= 1'b0;
      if (rd)                           bus_rdata <= rd_mux;
      irq_alarm <= al_q && ien_q[3];
      irq_sec   <= stepped && ien_q[2];
    end
  end

  a_r6_alarm_after_step: assert property (@(posedge clk) disable iff (rst)
    $rose(al_q) |-> $past(stepped));
  a_r7_pu_only_by_write: assert property (@(posedge clk) disable iff (rst)
    $fell(pu_q) |-> ($past(stat_wr) && $past(bus_wdata[7])));
  a_r10_sec_single_pulse: assert property (@(posedge clk) disable iff (rst)
    irq_sec |=> !irq_sec);
  a_r10_alarm_irq_src: assert property (@(posedge clk) disable iff (rst)
    irq_alarm |-> $past(al_q));
endmodule

// File: tb/bcd_rtc_tb_top.sv
`timescale 1ns/1ps
module bcd_rtc_tb_top;
  localparam int TPS = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b1;
  logic       bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_alarm, irq_sec;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit started = 0, done = 0;

  always #5 clk = ~clk;

  bcd_rtc #(.TICKS_PER_SEC(TPS)) dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_alarm(irq_alarm), .irq_sec(irq_sec)
  );

  // ---------------- behavioural reference ----------------
  logic [5:0][7:0] m_t, m_alm;
  logic [7:0] m_ctrl, m_ien, m_rd;
  int  m_cnt;
  bit  m_pu, m_alf, m_stepped, m_irqa, m_irqs;
  bit [3:0] m_ev;

  function automatic int b2i(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction
  function automatic logic [7:0] i2b(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction
  function automatic int mdays(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] m_read(input logic [7:0] a);
    if (a[1:0] == 0 && a[4:2] <= 5 && a[7:5] == 0) return m_t[a[4:2]];
    if (a[1:0] == 0 && a[4:2] <= 5 && a[7:5] == 1) return m_alm[a[4:2]];
    if (a == 8'h40) return m_ctrl;
    if (a == 8'h44) return {m_pu, m_alf, m_ev, m_ctrl[0], (m_ctrl[0] && m_cnt == TPS-1)};
    if (a == 8'h48) return m_ien;
    return 8'h00;
  endfunction

  task automatic m_step();
    int s = b2i(m_t[0]), mi = b2i(m_t[1]), h = b2i(m_t[2]);
    int d = b2i(m_t[3]), mo = b2i(m_t[4]), y = b2i(m_t[5]);
    m_ev = 4'b0001;
    if (s == 59) begin
      s = 0; m_ev[1] = 1;
      if (mi == 59) begin
        mi = 0; m_ev[2] = 1;
        if (h == 23) begin
          h = 0; m_ev[3] = 1;
          if (d == mdays(mo, y)) begin
            d = 1;
            if (mo == 12) begin mo = 1; y = (y == 99) ? 0 : y + 1; end
            else mo = mo + 1;
          end else d = d + 1;
        end else h = h + 1;
      end else mi = mi + 1;
    end else s = s + 1;
    m_t = {i2b(y), i2b(mo), i2b(d), i2b(h), i2b(mi), i2b(s)};
  endtask

  always @(posedge clk) begin
    bit wr, twr, hit, strobe;
    started <= 1;
    if (rst) begin
      m_t = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
      m_alm = '0; m_ctrl = 0; m_ien = 0; m_rd = 0; m_cnt = 0;
      m_pu = 1; m_alf = 0; m_stepped = 0; m_irqa = 0; m_irqs = 0; m_ev = 0;
    end else begin
      wr  = bus_en && bus_we;
      twr = wr && bus_addr[1:0] == 0 && bus_addr[4:2] <= 5 && bus_addr[7:5] == 0;
      if (bus_en && !bus_we) m_rd = m_read(bus_addr);
      m_irqa = m_alf && m_ien[3];
      m_irqs = m_stepped && m_ien[2];
      hit    = m_stepped && (m_t == m_alm);
      strobe = m_ctrl[0] && tick_en && (m_cnt == TPS-1);
      if (wr && bus_addr == 8'h44) begin
        if (bus_wdata[7]) m_pu = 0;
        if (bus_wdata[6]) m_alf = 0;
      end
      if (hit) m_alf = 1;
      if (twr && bus_addr[4:2] == 0) m_cnt = 0;
      else if (m_ctrl[0] && tick_en) m_cnt = (m_cnt == TPS-1) ? 0 : m_cnt + 1;
      m_stepped = 0;
      if (twr) m_t[bus_addr[4:2]] = bus_wdata;
      else if (strobe) begin m_step(); m_stepped = 1; end
      if (wr && bus_addr[1:0] == 0 && bus_addr[4:2] <= 5 && bus_addr[7:5] == 1)
        m_alm[bus_addr[4:2]] = bus_wdata;
      if (wr && bus_addr == 8'h40) m_ctrl = bus_wdata & 8'h8D;
      if (wr && bus_addr == 8'h48) m_ien  = bus_wdata & 8'h0C;
    end
  end

  // every-cycle comparison, half a cycle after the edge
  always @(negedge clk) begin
    if (started && !done) begin
      n_cmp++;
      if (bus_rdata !== m_rd || irq_alarm !== m_irqa || irq_sec !== m_irqs) begin
        n_bad++;
        $display("FAIL %s: rdata/irq_alarm/irq_sec actual %h/%b/%b expected %h/%b/%b at %0t",
                 cur_req, bus_rdata, irq_alarm, irq_sec, m_rd, m_irqa, m_irqs, $time);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic bwr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_en = 0; d = bus_rdata;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] d;
    brd(a, d);
    n_cmp++;
    if (d !== exp) begin
      n_bad++;
      $display("FAIL %s: addr %h actual %h expected %h", tag, a, d, exp);
    end
  endtask

  task automatic set_time(input logic [7:0] y, mo, d, h, mi, s);
    bwr(8'h40, 8'h00);
    bwr(8'h14, y); bwr(8'h10, mo); bwr(8'h0C, d);
    bwr(8'h08, h); bwr(8'h04, mi); bwr(8'h00, s);
    bwr(8'h40, 8'h01);
  endtask

  task automatic one_sec();
    repeat (18) @(negedge clk);
  endtask

  initial begin
    int pulses;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    cur_req = "R1";
    expect_rd(8'h00, 8'h00, "R1"); expect_rd(8'h0C, 8'h01, "R1");
    expect_rd(8'h10, 8'h01, "R1"); expect_rd(8'h44, 8'h80, "R1");
    expect_rd(8'h40, 8'h00, "R1"); expect_rd(8'h48, 8'h00, "R1");

    // R11 register map masks
    cur_req = "R11";
    bwr(8'h40, 8'hFE); expect_rd(8'h40, 8'h8C, "R11");
    bwr(8'h48, 8'hFF); expect_rd(8'h48, 8'h0C, "R11");
    expect_rd(8'h3C, 8'h00, "R11"); expect_rd(8'h18, 8'h00, "R11");
    bwr(8'h48, 8'h00); bwr(8'h40, 8'h00);

    // R2 stopped clock does not count; tick gating
    cur_req = "R2";
    repeat (40) @(negedge clk);
    expect_rd(8'h00, 8'h00, "R2");
    bwr(8'h40, 8'h01);
    tick_en = 0; repeat (50) @(negedge clk); tick_en = 1;
    expect_rd(8'h00, 8'h00, "R2");
    repeat (3 * TPS) @(negedge clk);

    // R3, R9 rollovers and event bits
    cur_req = "R3";
    set_time(8'h24, 8'h06, 8'h15, 8'h23, 8'h59, 8'h59); one_sec();
    expect_rd(8'h08, 8'h00, "R3"); expect_rd(8'h04, 8'h00, "R3");
    expect_rd(8'h0C, 8'h16, "R3");
    cur_req = "R9";
    expect_rd(8'h44, 8'hBE, "R9");
    set_time(8'h24, 8'h06, 8'h15, 8'h10, 8'h20, 8'h30); one_sec();
    expect_rd(8'h44, 8'h86, "R9");

    // R4 month lengths and leap years
    cur_req = "R4";
    set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); one_sec();
    expect_rd(8'h0C, 8'h29, "R4"); expect_rd(8'h10, 8'h02, "R4");
    set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); one_sec();
    expect_rd(8'h0C, 8'h01, "R4"); expect_rd(8'h10, 8'h03, "R4");
    set_time(8'h00, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59); one_sec();
    expect_rd(8'h10, 8'h03, "R4");
    set_time(8'h31, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59); one_sec();
    expect_rd(8'h10, 8'h05, "R4"); expect_rd(8'h0C, 8'h01, "R4");
    set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59); one_sec();
    expect_rd(8'h14, 8'h00, "R4"); expect_rd(8'h10, 8'h01, "R4");

    // R7 write-one-to-clear
    cur_req = "R7";
    bwr(8'h44, 8'h3F); expect_rd(8'h44, 8'hBE, "R7");
    bwr(8'h44, 8'h80); expect_rd(8'h44, 8'h3E, "R7");

    // R6 partial match then full match, R10 alarm irq
    cur_req = "R6";
    bwr(8'h48, 8'h08);
    bwr(8'h34, 8'h26); bwr(8'h30, 8'h07); bwr(8'h2C, 8'h05);
    bwr(8'h28, 8'h12); bwr(8'h24, 8'h30); bwr(8'h20, 8'h45);
    set_time(8'h25, 8'h07, 8'h05, 8'h12, 8'h30, 8'h44); one_sec();
    expect_rd(8'h44, 8'h06, "R6");
    bwr(8'h34, 8'h25);
    set_time(8'h25, 8'h07, 8'h05, 8'h12, 8'h30, 8'h44); one_sec();
    expect_rd(8'h44, 8'h46, "R6");
    cur_req = "R10";
    n_cmp++;
    if (irq_alarm !== 1'b1) begin
      n_bad++; $display("FAIL R10: irq_alarm actual %b expected 1", irq_alarm);
    end
    cur_req = "R7";
    bwr(8'h44, 8'h40); expect_rd(8'h44, 8'h06, "R7");

    // R10 periodic pulses
    cur_req = "R10";
    bwr(8'h48, 8'h04); bwr(8'h40, 8'h00); bwr(8'h00, 8'h00);
    bwr(8'h40, 8'h01);
    pulses = 0;
    for (int i = 0; i < 5 * TPS + 4; i++) begin
      @(negedge clk);
      if (irq_sec) pulses++;
    end
    n_cmp++;
    if (pulses != 5) begin
      n_bad++; $display("FAIL R10: irq_sec pulses actual %0d expected 5", pulses);
    end

    // R8 busy polling, compared each cycle against the model
    cur_req = "R8";
    for (int i = 0; i < 2 * TPS; i++) begin
      logic [7:0] d;
      brd(8'h44, d);
    end

    // R5 writes near the step edge, restart of the prescaler
    cur_req = "R5";
    for (int off = 10; off < 22; off++) begin
      bwr(8'h00, 8'h10);
      repeat (off) @(negedge clk);
      bwr(8'h04, 8'h33);
      repeat (TPS + 2) @(negedge clk);
    end
    bwr(8'h40, 8'h00);
    bwr(8'h00, 8'h20); bwr(8'h40, 8'h01);
    repeat (TPS - 4) @(negedge clk);
    expect_rd(8'h00, 8'h20, "R5");
    repeat (4) @(negedge clk);
    expect_rd(8'h00, 8'h21, "R5");

    // R2 stop holds time
    cur_req = "R2";
    bwr(8'h40, 8'h00);
    repeat (3 * TPS) @(negedge clk);
    expect_rd(8'h00, 8'h21, "R2");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule